// File: doc/BRIEF.md
# Channel Configuration and Status Register

This block is the 16-bit configuration and status word of one transceiver channel. A management register port reaches it. A read strobe returns the word and clears the status bits that latch. A write strobe loads the fields software may change. The frame engine of the serial management bus is not part of the block: it presents the strobes and the 16-bit data, and it takes `rd_data` in the cycle of the read strobe. The block's own datapath is not here either: overrun, underrun and receive-error events arrive as one-cycle pulses, and the auto-negotiation state arrives as a level.

While reset is held, the block copies its control fields from strap pins, so the word comes out of reset already configured for the board. Each field that software writes takes effect on the next clock edge and needs no further reset. The channel is switched off when either the strap disable pin or the software disable bit is set. The broadcast control belongs to the redundant-link arrangement. It exists only on the lower-numbered channels, and software can change it only while redundant mode is enabled.

Top module: `chan_cfg_reg`

## Requirements
- R1: While `rst_n` is low, the next clock edge loads these values: bit 15 = 0, bits 13, 12 and 11 = 0, bit 10 = `strap_clk_cent`, bit 9 = `strap_bcast & redund_en` (0 when `CHAN_IDX >= BCAST_CHANS`), bit 8 = `strap_rsel`, bits 7:0 = 0.
- R2: Bit 15 is a software disable that a write sets or clears. Bit 14 shows `strap_xcvr_dis` with no delay. `chan_disable` equals bit 15 OR bit 14.
- R3: Bit 13 (overrun) goes to 1 on the edge after an `ovr_evt` pulse. It then holds until a read strobe clears it, and writes never change it.
- R4: Bit 12 (underrun) behaves like bit 13, driven by `unr_evt`.
- R5: An overrun or underrun event in the same cycle as a read strobe leaves its bit set after the read. That read returns the value the bit had before the event.
- R6: Bit 11 shows `aneg_active` as it was at the previous clock edge. Writes to bits 14 to 11 are ignored.
- R7: Bits 10 (receive-clock centering) and 8 (rate select) take `wr_data` bits 10 and 8 on the edge of a write strobe.
- R8: Bit 9 (broadcast) takes `wr_data[9]` on a write only when `redund_en` is high and `CHAN_IDX < BCAST_CHANS`. Otherwise it keeps its value.
- R9: Bits 7:0 count `rx_err` pulses and stop at 255. Writes never change them.
- R10: A read strobe clears the error count. A `rx_err` pulse in the same cycle as the read leaves the count at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; the straps are sampled while it is low |
| strap_xcvr_dis | input | 1 | Hardware channel-disable pin |
| strap_clk_cent | input | 1 | Strap giving the reset value of receive-clock centering |
| strap_bcast | input | 1 | Strap giving the reset value of broadcast |
| strap_rsel | input | 1 | Strap giving the reset value of rate select |
| redund_en | input | 1 | Redundant mode enable |
| ovr_evt | input | 1 | Overrun event pulse |
| unr_evt | input | 1 | Underrun event pulse |
| aneg_active | input | 1 | Transmitter is in auto-negotiation |
| rx_err | input | 1 | Receive error pulse |
| rd_stb | input | 1 | Register read strobe; clears the sticky bits and the counter |
| wr_stb | input | 1 | Register write strobe |
| wr_data | input | 16 | Write data |
| rd_data | output | 16 | Current register word |
| chan_disable | output | 1 | Combined channel disable |

## Verification
The bench builds two copies. One has `CHAN_IDX = 0`, where broadcast exists. The other has `CHAN_IDX = 2`, where broadcast is tied off. With one set of stimulus the bench can therefore compare the mode-dependent write lock against the absent field. It sweeps every combination of the four straps and the redundant enable through reset. It writes every value of the upper byte in both modes. It counts every error run length from 0 to 20 and several runs past 255, and it places events and errors in the same cycle as the clearing read.

// File: rtl/chan_cfg_pkg.sv
// Package: bit positions and widths of the channel configuration word.
// Assumes a 16-bit register with an 8-bit error counter in the low byte.
package chan_cfg_pkg;
    localparam int REG_W     = 16;
    localparam int CNT_W     = 8;
    localparam int B_SW_DIS  = 15;
    localparam int B_PIN_DIS = 14;
    localparam int B_OVR     = 13;
    localparam int B_UNR     = 12;
    localparam int B_ANEG    = 11;
    localparam int B_CENT    = 10;
    localparam int B_BCAST   = 9;
    localparam int B_RSEL    = 8;
endpackage

// File: rtl/cfg_sticky_flag.sv
// Module: status bit that latches high and clears on a read strobe.
// Assumes that an event coinciding with the clear must survive the clear.
module cfg_sticky_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    // Latch events; a read reloads the flag from the event input.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag_o <= 1'b0;
        else if (clr_i)
            flag_o <= set_i;
        else if (set_i)
            flag_o <= 1'b1;
    end
endmodule

// File: rtl/cfg_err_counter.sv
// Module: saturating event counter that clears on read.
// Assumes at most one event per cycle; an event during the clear counts as one.
module cfg_err_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         inc_i,
    input  logic         clr_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    // Count up to the maximum, or restart from the current event on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_o <= '0;
        else if (clr_i)
            cnt_o <= {{(W-1){1'b0}}, inc_i};
        else if (inc_i && cnt_o != CNT_MAX)
            cnt_o <= cnt_o + 1'b1;
    end
endmodule

// File: rtl/cfg_ctrl_bits.sv
// Module: software-writable control fields with reset values taken from straps.
// Assumes the straps are stable while reset is held. HAS_BCAST selects
// whether this channel implements the broadcast field.
module cfg_ctrl_bits #(
    parameter bit HAS_BCAST = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_clk_cent,
    input  logic        strap_bcast,
    input  logic        strap_rsel,
    input  logic        redund_en,
    input  logic        wr_stb,
    input  logic [15:0] wr_data,
    output logic        sw_dis_o,
    output logic        cent_o,
    output logic        bcast_o,
    output logic        rsel_o
);
    import chan_cfg_pkg::*;

    // Load the unconditional fields from straps in reset, from write data afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sw_dis_o <= 1'b0;
            cent_o   <= strap_clk_cent;
            rsel_o   <= strap_rsel;
        end else if (wr_stb) begin
            sw_dis_o <= wr_data[B_SW_DIS];
            cent_o   <= wr_data[B_CENT];
            rsel_o   <= wr_data[B_RSEL];
        end
    end

    generate
        if (HAS_BCAST) begin : g_bcast
            // Broadcast: strap qualified by redundant mode, written only in that mode.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    bcast_o <= strap_bcast & redund_en;
                else if (wr_stb && redund_en)
                    bcast_o <= wr_data[B_BCAST];
            end
        end else begin : g_no_bcast
            assign bcast_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/chan_cfg_reg.sv
// Module: channel configuration and status register, top level.
// Assumes rd_data is taken by the management engine in the cycle of rd_stb;
// the clear-on-read fields change on the edge that ends that cycle.
module chan_cfg_reg #(
    parameter int CHAN_IDX    = 0,
    parameter int BCAST_CHANS = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        strap_xcvr_dis,
    input  logic        strap_clk_cent,
    input  logic        strap_bcast,
    input  logic        strap_rsel,
    input  logic        redund_en,
    input  logic        ovr_evt,
    input  logic        unr_evt,
    input  logic        aneg_active,
    input  logic        rx_err,
    input  logic        rd_stb,
    input  logic        wr_stb,
    input  logic [15:0] wr_data,
    output logic [15:0] rd_data,
    output logic        chan_disable
);
    import chan_cfg_pkg::*;

    localparam bit HAS_BCAST = (CHAN_IDX < BCAST_CHANS);

    logic             sw_dis, cent, bcast, rsel;
    logic             ovr_q, unr_q, aneg_q;
    logic [CNT_W-1:0] err_cnt;

    cfg_ctrl_bits #(.HAS_BCAST(HAS_BCAST)) u_ctrl (
        .clk(clk), .rst_n(rst_n),
        .strap_clk_cent(strap_clk_cent), .strap_bcast(strap_bcast),
        .strap_rsel(strap_rsel), .redund_en(redund_en),
        .wr_stb(wr_stb), .wr_data(wr_data),
        .sw_dis_o(sw_dis), .cent_o(cent), .bcast_o(bcast), .rsel_o(rsel)
    );

    cfg_sticky_flag u_ovr (
        .clk(clk), .rst_n(rst_n), .set_i(ovr_evt), .clr_i(rd_stb), .flag_o(ovr_q)
    );

    cfg_sticky_flag u_unr (
        .clk(clk), .rst_n(rst_n), .set_i(unr_evt), .clr_i(rd_stb), .flag_o(unr_q)
    );

    cfg_err_counter #(.W(CNT_W)) u_cnt (
        .clk(clk), .rst_n(rst_n), .inc_i(rx_err), .clr_i(rd_stb), .cnt_o(err_cnt)
    );

    // Register the auto-negotiation level for the read-only status bit.
    always_ff @(posedge clk) begin
        if (!rst_n)
            aneg_q <= 1'b0;
        else
            aneg_q <= aneg_active;
    end

    // Assemble the register word from the field sources.
    always_comb begin
        rd_data              = '0;
        rd_data[B_SW_DIS]    = sw_dis;
        rd_data[B_PIN_DIS]   = strap_xcvr_dis;
        rd_data[B_OVR]       = ovr_q;
        rd_data[B_UNR]       = unr_q;
        rd_data[B_ANEG]      = aneg_q;
        rd_data[B_CENT]      = cent;
        rd_data[B_BCAST]     = bcast;
        rd_data[B_RSEL]      = rsel;
        rd_data[CNT_W-1:0]   = err_cnt;
    end

    // Channel is off when either the pin or software asks for it.
    assign chan_disable = sw_dis | strap_xcvr_dis;
endmodule

// File: rtl/chan_cfg_reg_chk.sv
// Module: assertion checker for chan_cfg_reg, attached with bind.
// Assumes it sees the top-level ports only.
module chan_cfg_reg_chk #(
    parameter int CHAN_IDX    = 0,
    parameter int BCAST_CHANS = 2
) (
    input logic        clk,
    input logic        rst_n,
    input logic        redund_en,
    input logic        ovr_evt,
    input logic        unr_evt,
    input logic        rx_err,
    input logic        rd_stb,
    input logic        wr_stb,
    input logic [15:0] rd_data,
    input logic        chan_disable
);
    AST_DIS_COMBINE: assert property (@(posedge clk) disable iff (!rst_n)
        chan_disable == (rd_data[15] | rd_data[14])); // R2
    AST_OVR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_evt |=> rd_data[13]); // R3
    AST_OVR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[13] && !rd_stb) |=> rd_data[13]); // R3
    AST_OVR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && !ovr_evt) |=> !rd_data[13]); // R3
    AST_UNR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        unr_evt |=> rd_data[12]); // R4
    AST_UNR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[12] && !rd_stb) |=> rd_data[12]); // R4
    AST_EVT_IN_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && unr_evt) |=> rd_data[12]); // R5
    AST_BCAST_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_stb || !redund_en || CHAN_IDX >= BCAST_CHANS) |=> $stable(rd_data[9])); // R8
    AST_CNT_SAT: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_data[7:0] == 8'hFF && !rd_stb) |=> rd_data[7:0] == 8'hFF); // R9
    AST_CNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_stb && !rx_err) |=> $stable(rd_data[7:0])); // R9
    AST_CNT_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stb && rx_err) |=> rd_data[7:0] == 8'd1); // R10
endmodule

bind chan_cfg_reg chan_cfg_reg_chk #(.CHAN_IDX(CHAN_IDX), .BCAST_CHANS(BCAST_CHANS)) u_chk (
    .clk(clk), .rst_n(rst_n), .redund_en(redund_en), .ovr_evt(ovr_evt),
    .unr_evt(unr_evt), .rx_err(rx_err), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .rd_data(rd_data), .chan_disable(chan_disable)
);

// File: tb/chan_cfg_reg_test.sv
module chan_cfg_reg_test;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_dis = 0, s_cent = 0, s_bc = 0, s_rsel = 0, red = 0;
    logic        ovr = 0, unr = 0, aneg = 0, err = 0, rd = 0, wr = 0;
    logic [15:0] wd = '0;
    logic [15:0] q0, q2;
    logic        dis0, dis2;
    int          n_chk = 0, n_bad = 0;
    logic [15:0] v;

    always #(PERIOD/2) clk = ~clk;

    chan_cfg_reg #(.CHAN_IDX(0)) uut (
        .clk(clk), .rst_n(rst_n), .strap_xcvr_dis(s_dis), .strap_clk_cent(s_cent),
        .strap_bcast(s_bc), .strap_rsel(s_rsel), .redund_en(red), .ovr_evt(ovr),
        .unr_evt(unr), .aneg_active(aneg), .rx_err(err), .rd_stb(rd), .wr_stb(wr),
        .wr_data(wd), .rd_data(q0), .chan_disable(dis0));

    chan_cfg_reg #(.CHAN_IDX(2)) uut_hi (
        .clk(clk), .rst_n(rst_n), .strap_xcvr_dis(s_dis), .strap_clk_cent(s_cent),
        .strap_bcast(s_bc), .strap_rsel(s_rsel), .redund_en(red), .ovr_evt(ovr),
        .unr_evt(unr), .aneg_active(aneg), .rx_err(err), .rd_stb(rd), .wr_stb(wr),
        .wr_data(wd), .rd_data(q2), .chan_disable(dis2));

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    task automatic do_write(input logic [15:0] w);
        wr = 1'b1; wd = w;
        step();
        wr = 1'b0;
    endtask

    // Read both copies: value returned in the strobe cycle.
    task automatic do_read(output logic [15:0] r0, output logic [15:0] r2);
        rd = 1'b1;
        #1; r0 = q0; r2 = q2;
        step();
        rd = 1'b0;
    endtask

    initial begin : watchdog
        #(PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        logic [15:0] r0, r2, e;
        step();
        // R1 reset values over every strap and mode combination
        for (int k = 0; k < 32; k++) begin
            {s_dis, s_cent, s_bc, s_rsel, red} = k[4:0];
            do_reset();
            e = {1'b0, s_dis, 3'b000, s_cent, s_bc & red, s_rsel, 8'h00};
            check("R1 reset ch0", q0, e);
            e[9] = 1'b0;
            check("R1 reset ch2", q2, e);
        end
        s_dis = 0; s_cent = 0; s_bc = 0; s_rsel = 0; red = 0;
        do_reset();

        // R7 R8 R6 every upper byte written in both modes
        for (int m = 0; m < 2; m++) begin
            for (int b = 0; b < 256; b++) begin
                logic prev0;
                red = m[0];
                prev0 = q0[9];
                do_write({b[7:0], 8'hFF});
                e = {b[7], 4'b0000, b[2], (red ? b[1] : prev0), b[0], 8'h00};
                check("R7 R8 R9 write ch0", q0, e);
                e[9] = 1'b0;
                check("R6 R8 write ch2", q2, e);
            end
        end
        red = 0;

        // R2 disable combination
        for (int k = 0; k < 4; k++) begin
            s_dis = k[0];
            do_write({k[1], 15'h0});
            #1;
            check("R2 disable out", {15'h0, dis0}, {15'h0, k[0] | k[1]});
            check("R2 pin mirror", {15'h0, q0[14]}, {15'h0, k[0]});
        end
        s_dis = 0; do_write(16'h0);

        // R3 R4 sticky capture, hold, write immunity, clear
        for (int k = 0; k < 2; k++) begin
            if (k == 0) ovr = 1; else unr = 1;
            step(); ovr = 0; unr = 0;
            step(); step();
            do_write(16'h0000);
            do_read(r0, r2);
            check(k == 0 ? "R3 overrun held" : "R4 underrun held",
                  r0 & 16'h3000, k == 0 ? 16'h2000 : 16'h1000);
            #1;
            check(k == 0 ? "R3 cleared" : "R4 cleared", q0 & 16'h3000, 16'h0);
        end

        // R5 event coincident with read
        ovr = 1; unr = 1;
        do_read(r0, r2);
        ovr = 0; unr = 0;
        check("R5 read value", r0 & 16'h3000, 16'h0);
        #1; check("R5 kept", q0 & 16'h3000, 16'h3000);
        do_read(r0, r2);

        // R6 auto-negotiation one edge late, write ignored
        aneg = 1;
        #1; check("R6 before edge", {15'h0, q0[11]}, 16'h0);
        step();
        check("R6 after edge", {15'h0, q0[11]}, 16'h1);
        do_write(16'h0000);
        check("R6 ro", {15'h0, q0[11]}, 16'h1);
        aneg = 0; step();

        // R9 R10 counter sweep
        for (int n = 0; n < 26; n++) begin
            int cnt;
            cnt = (n <= 20) ? n : 250 + (n - 21) * 10;
            for (int i = 0; i < cnt; i++) begin err = 1; step(); end
            err = 0;
            do_read(r0, r2);
            check("R9 count", {8'h0, r0[7:0]}, {8'h0, (cnt > 255) ? 8'd255 : 8'(cnt)});
            #1; check("R10 cleared", {8'h0, q0[7:0]}, 16'h0);
        end
        for (int i = 0; i < 5; i++) begin err = 1; step(); end
        err = 1;
        do_read(r0, r2);
        err = 0;
        check("R10 read value", {8'h0, r0[7:0]}, 16'd5);
        #1; check("R10 error in read", {8'h0, q0[7:0]}, 16'd1);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule